// File: doc/BRIEF.md
# Four-Read Burst Channel Picker

This block sits between a four-channel sampling converter with a sequential read port and the logic that consumes one of its results. When the converter signals the end of a conversion sequence by pulling its active-low interrupt line down, the block takes over the read port. It asserts chip select and generates four read strobes from the system clock. During the read whose position matches a 2-bit channel selector, it copies the data bus into a holding register. No processor is involved.

All four reads are always issued, whichever channel is selected. This brings the converter's internal read pointer back to channel 1 after every burst. The low time of each strobe and the gap between strobes are set in clock cycles. They are chosen to meet the converter's minimum read-low and read-spacing times at the system clock rate. A one-cycle flag marks each new capture. The interrupt input is asynchronous and passes through a synchronizer before edge detection.

Top module: `burst_pick`

## Requirements
- R1: While reset is asserted and right after it is released, `cs_n` and `rd_n` are high, `fresh` is low and `held_word` is zero.
- R2: A high-to-low transition on `irq_n` starts a burst. `cs_n` goes low exactly SYNC_STAGES+1 clock cycles after the cycle in which `irq_n` falls. A steady high `irq_n` starts nothing.
- R3: Every burst has exactly four low pulses on `rd_n`. `rd_n` is low only while `cs_n` is low. After the burst, four rising edges of `rd_n` have been seen, so a reader that advances on each rising edge is back at its first word.
- R4: Each `rd_n` low pulse lasts exactly LOW_CYC cycles. Between consecutive pulses, and after the fourth pulse before `cs_n` returns high, `rd_n` stays high for exactly GAP_CYC cycles.
- R5: The selector values 0, 1, 2 and 3 (`sel` bits [1:0]) pick read pulses 1, 2, 3 and 4. The value on `rd_data` at the last clock edge of the picked pulse's low phase is stored in `held_word`.
- R6: `sel` is sampled when a burst starts. Changes to `sel` during the burst do not alter which pulse is captured.
- R7: `fresh` is high for exactly one cycle per burst. In that cycle `held_word` already shows the new word.
- R8: Between bursts, `held_word` keeps its value whatever appears on `rd_data`.
- R9: A further falling edge of `irq_n` while a burst is running is ignored. It adds no read pulse and starts no burst after the current one ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobe timing counts its cycles |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_n | input | 1 | End-of-conversion line from the converter, active low, asynchronous |
| sel | input | 2 | Read position to capture (0 = first word) |
| rd_data | input | DATA_W | Converter data bus |
| cs_n | output | 1 | Chip select to the converter, low for the whole burst |
| rd_n | output | 1 | Read strobe to the converter, active low |
| held_word | output | DATA_W | Last captured word |
| fresh | output | 1 | One-cycle pulse when `held_word` has been updated |

## Verification
The bench builds the block with LOW_CYC=3, GAP_CYC=2 and SYNC_STAGES=2, so one burst takes twenty cycles. Interrupt edges injected a few cycles into a burst therefore land inside a strobe or a gap, not after the burst. The small widths make off-by-one errors in pulse length, gap length and tail length show up directly as run-length mismatches. The two-stage synchronizer gives a start latency of three cycles, which is checked on every burst. A reader model drives a different value on the bus outside read-low phases and advances its pointer on each strobe rising edge. A capture at the wrong edge or the wrong position therefore gives a wrong word.

// File: rtl/burst_pick_pkg.sv
// Shared constants and types for the burst channel picker.
// Assumes the attached converter exposes exactly four result words per burst.
package burst_pick_pkg;
    localparam int NUM_READS = 4;
    localparam int IDX_W     = $clog2(NUM_READS);

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_GAP  = 2'd2
    } strobe_phase_t;
endpackage

// File: rtl/irq_edge_sync.sv
// Brings the asynchronous active-low interrupt into the clock domain and
// flags its falling edge for one cycle.
// Assumes SYNC_STAGES >= 2 and that irq_n idles high out of reset.
module irq_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_n,
    output logic fall
);
    logic [SYNC_STAGES-1:0] chain;
    logic                   last_q;

    // Shift the raw line through the synchronizer and keep one extra copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain  <= '1;
            last_q <= 1'b1;
        end else begin
            chain[0] <= irq_n;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
            last_q <= chain[SYNC_STAGES-1];
        end
    end

    // High for one cycle when the synchronized line goes from 1 to 0.
    always_comb begin
        fall = last_q & ~chain[SYNC_STAGES-1];
    end

    // R2
    fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/read_strobe_seq.sv
// Issues four read strobes under chip select once started. Each strobe is
// low for LOW_CYC cycles and followed by GAP_CYC high cycles.
// Assumes LOW_CYC >= 1 and GAP_CYC >= 1. Start requests while busy are dropped.
module read_strobe_seq
    import burst_pick_pkg::*;
#(
    parameter int LOW_CYC = 6,
    parameter int GAP_CYC = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic             slot_end,
    output logic [IDX_W-1:0] slot_idx,
    output logic             cs_n,
    output logic             rd_n
);
    localparam int CNT_MAX = (LOW_CYC > GAP_CYC) ? LOW_CYC : GAP_CYC;
    localparam int CNT_W   = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;
    localparam logic [CNT_W-1:0] LOW_LAST = CNT_W'(LOW_CYC - 1);
    localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_CYC - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_READS - 1);

    strobe_phase_t    ph, ph_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic [IDX_W-1:0] idx, idx_nxt;

    // Next-state decode for the phase, in-phase counter and pulse index.
    always_comb begin
        ph_nxt  = ph;
        cnt_nxt = cnt;
        idx_nxt = idx;
        case (ph)
            PH_IDLE: begin
                if (start) begin
                    ph_nxt  = PH_LOW;
                    cnt_nxt = '0;
                    idx_nxt = '0;
                end
            end
            PH_LOW: begin
                if (cnt == LOW_LAST) begin
                    ph_nxt  = PH_GAP;
                    cnt_nxt = '0;
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            PH_GAP: begin
                if (cnt == GAP_LAST) begin
                    cnt_nxt = '0;
                    if (idx == IDX_LAST) begin
                        ph_nxt = PH_IDLE;
                    end else begin
                        ph_nxt  = PH_LOW;
                        idx_nxt = idx + 1'b1;
                    end
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            default: ph_nxt = PH_IDLE;
        endcase
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph  <= PH_IDLE;
            cnt <= '0;
            idx <= '0;
        end else begin
            ph  <= ph_nxt;
            cnt <= cnt_nxt;
            idx <= idx_nxt;
        end
    end

    // Strobe outputs straight from flops, decoded from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n <= 1'b1;
            rd_n <= 1'b1;
        end else begin
            cs_n <= (ph_nxt == PH_IDLE);
            rd_n <= (ph_nxt != PH_LOW);
        end
    end

    // Status seen by the capture logic.
    always_comb begin
        busy     = (ph != PH_IDLE);
        slot_end = (ph == PH_LOW) && (cnt == LOW_LAST);
        slot_idx = idx;
    end

    // R3
    strobe_under_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !cs_n);
    // R4
    gap_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_GAP) |-> rd_n);
    // R3
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_GAP && cnt == GAP_LAST && idx != IDX_LAST)
            |=> (ph == PH_LOW && idx == IDX_W'($past(idx) + 1'b1)));
    // R3
    burst_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_GAP && cnt == GAP_LAST && idx == IDX_LAST) |=> cs_n);
    // R9
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_LOW && start && cnt != LOW_LAST)
            |=> (ph == PH_LOW && idx == $past(idx)));
endmodule

// File: rtl/word_capture.sv
// Latches the selector at burst start and stores the data word at the end of
// the matching read-low phase, pulsing a one-cycle update flag.
// Assumes slot_end is high for one cycle per read pulse.
module word_capture
    import burst_pick_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              busy,
    input  logic [IDX_W-1:0]  sel,
    input  logic              slot_end,
    input  logic [IDX_W-1:0]  slot_idx,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] held_word,
    output logic              fresh
);
    logic [IDX_W-1:0] sel_q;
    logic             take;

    // Capture happens on the last low cycle of the chosen pulse.
    always_comb begin
        take = slot_end && (slot_idx == sel_q);
    end

    // Freeze the selector when a burst is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (arm) begin
            sel_q <= sel;
        end
    end

    // Holding register and its update flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_word <= '0;
            fresh     <= 1'b0;
        end else begin
            fresh <= take;
            if (take) begin
                held_word <= rd_data;
            end
        end
    end

    // R7
    fresh_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fresh |=> !fresh);
    // R8
    held_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(held_word) |-> fresh);
    // R6
    sel_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(sel_q));
endmodule

// File: rtl/burst_pick.sv
// Top of the burst channel picker. An interrupt falling edge triggers four
// read strobes and captures the word at the selected read position.
// Assumes the converter drives valid data by the last cycle of each read-low phase.
module burst_pick
    import burst_pick_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int LOW_CYC     = 6,
    parameter int GAP_CYC     = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_n,
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] rd_data,
    output logic              cs_n,
    output logic              rd_n,
    output logic [DATA_W-1:0] held_word,
    output logic              fresh
);
    logic             fall;
    logic             busy;
    logic             arm;
    logic             slot_end;
    logic [IDX_W-1:0] slot_idx;

    irq_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .irq_n (irq_n),
        .fall  (fall)
    );

    // A burst is accepted only when the sequencer is idle.
    always_comb begin
        arm = fall && !busy;
    end

    read_strobe_seq #(.LOW_CYC(LOW_CYC), .GAP_CYC(GAP_CYC)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (fall),
        .busy     (busy),
        .slot_end (slot_end),
        .slot_idx (slot_idx),
        .cs_n     (cs_n),
        .rd_n     (rd_n)
    );

    word_capture #(.DATA_W(DATA_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .busy      (busy),
        .sel       (IDX_W'(sel)),
        .slot_end  (slot_end),
        .slot_idx  (slot_idx),
        .rd_data   (rd_data),
        .held_word (held_word),
        .fresh     (fresh)
    );

    // R7
    fresh_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fresh |-> $past(!cs_n));
endmodule

// File: tb/burst_pick_bench.sv
`timescale 1ns/1ps
module burst_pick_bench;
    localparam int LOW  = 3;
    localparam int GAP  = 2;
    localparam int SYNC = 2;
    localparam int DW   = 12;

    logic          clk   = 1'b0;
    logic          rst_n = 1'b0;
    logic          irq_n = 1'b1;
    logic [1:0]    sel   = 2'd0;
    logic [DW-1:0] rd_data;
    logic          cs_n, rd_n, fresh;
    logic [DW-1:0] held_word;

    always #2.5 clk = ~clk;

    burst_pick #(.DATA_W(DW), .LOW_CYC(LOW), .GAP_CYC(GAP), .SYNC_STAGES(SYNC)) u_burst_pick (
        .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .sel(sel), .rd_data(rd_data),
        .cs_n(cs_n), .rd_n(rd_n), .held_word(held_word), .fresh(fresh)
    );

    // Reader model: the pointer advances on each strobe rising edge.
    // The bus carries the inverted word outside read-low phases.
    logic [DW-1:0] words [4];
    int ptr = 0;
    assign rd_data = (!cs_n && !rd_n) ? words[ptr] : ~words[ptr];

    int checks = 0, failures = 0;
    bit done = 1'b0;
    int pulse_cnt, fresh_cnt, bad_low, bad_gap, bad_tail, bad_cs, burst_cnt;
    int low_run = 0, high_run = 0;
    bit first_pulse = 1'b1, prev_rd = 1'b1, prev_cs = 1'b1;
    logic [DW-1:0] fresh_val;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] exp_word(input logic [1:0] s);
        return words[s];
    endfunction

    // Monitor of strobe timing, sampled away from the active edge.
    always @(negedge clk) begin
        if (prev_cs && !cs_n) begin burst_cnt++; first_pulse = 1'b1; high_run = 0; end
        if (!prev_cs && cs_n && high_run != GAP) bad_tail++;
        if (!rd_n && cs_n) bad_cs++;
        if (!prev_rd && rd_n) begin
            if (low_run != LOW) bad_low++;
            ptr = (ptr + 1) % 4;
            high_run = 0;
        end
        if (!cs_n && rd_n) high_run++;
        if (prev_rd && !rd_n) begin
            pulse_cnt++;
            if (!first_pulse && high_run != GAP) bad_gap++;
            first_pulse = 1'b0;
            low_run = 0;
        end
        if (!rd_n) low_run++;
        if (fresh) begin fresh_cnt++; fresh_val = held_word; end
        prev_rd = rd_n;
        prev_cs = cs_n;
    end

    task automatic run_burst(input logic [1:0] s, input bit inject, input bit chg);
        int n;
        logic [DW-1:0] want, keep;
        for (int i = 0; i < 4; i++) words[i] = DW'($urandom);
        ptr = 0; pulse_cnt = 0; fresh_cnt = 0; bad_low = 0; bad_gap = 0;
        bad_tail = 0; bad_cs = 0; burst_cnt = 0;
        @(negedge clk);
        sel = s;
        irq_n = 1'b0;
        n = 0;
        while (cs_n && n < 50) begin @(negedge clk); n++; end
        chk(n == SYNC + 1, "R2", "start latency", n, SYNC + 1);
        n = 0;
        while (rd_n && n < 50) begin @(negedge clk); n++; end
        irq_n = 1'b1;
        if (chg) sel = ~s;
        if (inject) begin
            repeat (6) @(negedge clk);
            irq_n = 1'b0;
            repeat (3) @(negedge clk);
            irq_n = 1'b1;
        end
        n = 0;
        while (!cs_n && n < 200) begin @(negedge clk); n++; end
        want = exp_word(s);
        chk(held_word == want, chg ? "R6" : "R5", "captured word", int'(held_word), int'(want));
        chk(fresh_cnt == 1, "R7", "fresh pulses", fresh_cnt, 1);
        chk(fresh_val == want, "R7", "word during fresh", int'(fresh_val), int'(want));
        chk(pulse_cnt == 4, "R3", "read pulses", pulse_cnt, 4);
        chk(ptr == 0, "R3", "reader pointer wrapped", ptr, 0);
        chk(bad_cs == 0, "R3", "strobe outside select", bad_cs, 0);
        chk(bad_low == 0, "R4", "low width errors", bad_low, 0);
        chk(bad_gap == 0, "R4", "gap width errors", bad_gap, 0);
        chk(bad_tail == 0, "R4", "tail width errors", bad_tail, 0);
        keep = held_word;
        for (int i = 0; i < 4; i++) words[i] = DW'($urandom);
        repeat (15) @(negedge clk);
        chk(held_word == keep, "R8", "held between bursts", int'(held_word), int'(keep));
        chk(burst_cnt == 1, inject ? "R9" : "R2", "bursts started", burst_cnt, 1);
        chk(pulse_cnt == 4, inject ? "R9" : "R3", "pulses after idle", pulse_cnt, 4);
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 4; i++) words[i] = '0;
        pulse_cnt = 0; fresh_cnt = 0; bad_low = 0; bad_gap = 0;
        bad_tail = 0; bad_cs = 0; burst_cnt = 0;
        repeat (4) @(negedge clk);
        chk(cs_n == 1'b1 && rd_n == 1'b1, "R1", "strobes in reset", {cs_n, rd_n}, 3);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n == 1'b1 && rd_n == 1'b1, "R1", "strobes after reset", {cs_n, rd_n}, 3);
        chk(fresh == 1'b0, "R1", "fresh after reset", fresh, 0);
        chk(held_word == '0, "R1", "held after reset", int'(held_word), 0);
        repeat (20) @(negedge clk);
        chk(burst_cnt == 0 && cs_n, "R2", "no burst on steady high", burst_cnt, 0);
        // Directed: every selector value, then interference cases.
        for (int s = 0; s < 4; s++) run_burst(2'(s), 1'b0, 1'b0);
        run_burst(2'd3, 1'b1, 1'b1);
        run_burst(2'd0, 1'b0, 1'b1);
        run_burst(2'd2, 1'b1, 1'b0);
        // Random mix.
        for (int k = 0; k < 24; k++) begin
            run_burst(2'($urandom % 4), ($urandom % 3) == 0, ($urandom % 3) == 0);
        end
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 0, 1);
            report();
            $finish;
        end
    end
endmodule